// File: doc/BRIEF.md
# Asymmetric Integer Bypass Network

This block feeds source operands to an integer cluster of four execution units: two ALUs (units 0 and 1) and two address-generation units (units 2 and 3, the AGUs of lanes 0 and 1). Each unit may retire one tagged result per cycle. Each unit has two source operands, so the block serves eight operands.

For every operand the block compares the source tag against the results retiring in the same cycle. It takes a forwarded result where the wiring allows one, and otherwise the value held in the register file. The register file is built as four identical copies, one per unit. Each copy has two read ports and all four write ports. Selected operands are registered, so a result retired in cycle N is usable by its consumer in cycle N+1.

The forwarding matrix is deliberately incomplete. An ALU result reaches all eight operands. An AGU result reaches only the ALU of its own lane. Any other consumer of an AGU result is flagged not ready and must read the register file one cycle later. A flags result is produced and consumed only by the ALUs, and it is forwarded between them over its own path.

Top module: `intbyp_net`

## Requirements
- R1: An operand selected while source tags are presented in cycle M appears on `opnd` (operand k at bits k*DATA_W and up, with k = 2*unit + source) and on `opnd_rdy[k]` after the next rising clock edge. A register write in cycle N is returned by a plain register-file read presented in cycle N+1.
- R2: A valid result from unit 0 or unit 1 with a nonzero tag that equals operand k's source tag is forwarded to operand k, for every k from 0 to 7, with `opnd_rdy[k]` high.
- R3: A result from unit 2 is forwarded only to operands 0 and 1 (unit 0), and a result from unit 3 only to operands 2 and 3 (unit 1).
- R4: When operand k's tag matches only producers that are not allowed to forward to it, `opnd_rdy[k]` is low. The same read presented one cycle later returns the new value with `opnd_rdy[k]` high.
- R5: With no matching producer, operand k carries the register-file entry named by its tag. Every operand reads its own entry independently.
- R6: When several allowed producers match one tag, the lowest-numbered unit supplies the operand. When several units write one tag in the same cycle, the lowest-numbered unit's data is stored.
- R7: Tag 0 means no destination. A result with tag 0 changes no register and forwards to no operand. A source tag of 0 reads zero with `opnd_rdy` high.
- R8: `alu_flags` after an edge holds ALU0's flags result if `flg_wr[0]` was set, else ALU1's if `flg_wr[1]` was set, else its previous value. Flags results presented with `flg_wr` low are ignored.
- R9: All four register-file copies hold identical contents, so any two operands reading the same tag with no matching producer return equal values.
- R10: After reset, every register, every operand and `alu_flags` are zero, and all `opnd_rdy` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld | input | 4 | Result valid, one bit per unit |
| res_tag | input | 4*TAG_W | Destination tag per unit, unit u at bits u*TAG_W |
| res_data | input | 4*DATA_W | Result data per unit |
| flg_wr | input | 2 | Flags result valid, one bit per ALU |
| flg_res | input | 2*FLAG_W | Flags result per ALU |
| src_tag | input | 8*TAG_W | Source tag per operand k = 2*unit + source |
| opnd | output | 8*DATA_W | Registered operand values |
| opnd_rdy | output | 8 | Operand valid; low when a needed result cannot be forwarded |
| alu_flags | output | FLAG_W | Registered flags operand shared by both ALUs |

## Verification
Forwarding and register-file writeback of the same result happen in the same cycle. So do forwarding of one result and a plain read of another entry. The bench retires a result from each unit in turn on every tag while all eight operands read that tag. It checks forwarded or not-ready per operand against its own connectivity rule, then repeats the read one cycle later to judge the stored copy. It also makes two units collide on one tag, so that priority in the forwarded value and in the stored value are judged together. Sweeps with a different register on each operand check that the copies stay identical.

// File: rtl/intbyp_pkg.sv
package intbyp_pkg;
    localparam int NUNIT    = 4;
    localparam int NALU     = 2;
    localparam int SRC_PER  = 2;
    localparam int NOPND    = NUNIT * SRC_PER;

    // producer prod may feed consumer unit cons
    function automatic logic may_fwd(input int prod, input int cons);
        if (prod < NALU)
            return 1'b1;
        return (prod - NALU) == cons;
    endfunction
endpackage

// File: rtl/intbyp_rf_copy.sv
module intbyp_rf_copy
    import intbyp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUNIT-1:0]          wr_vld,
    input  logic [NUNIT*TAG_W-1:0]    wr_tag,
    input  logic [NUNIT*DATA_W-1:0]   wr_data,
    input  logic [SRC_PER*TAG_W-1:0]  rd_tag,
    output logic [SRC_PER*DATA_W-1:0] rd_data
);
    localparam int NREG = 2 ** TAG_W;

    logic [DATA_W-1:0] mem_d [NREG];
    logic [DATA_W-1:0] mem_q [NREG];

    always_comb begin
        for (int r = 0; r < NREG; r++)
            mem_d[r] = mem_q[r];
        // highest unit first so the lowest-numbered writer lands last
        for (int u = NUNIT - 1; u >= 0; u--) begin
            if (wr_vld[u] && (wr_tag[u*TAG_W +: TAG_W] != '0))
                mem_d[wr_tag[u*TAG_W +: TAG_W]] = wr_data[u*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++)
                mem_q[r] <= '0;
        end else begin
            for (int r = 0; r < NREG; r++)
                mem_q[r] <= mem_d[r];
        end
    end

    generate
        for (genvar s = 0; s < SRC_PER; s++) begin : g_rd
            assign rd_data[s*DATA_W +: DATA_W] = mem_q[rd_tag[s*TAG_W +: TAG_W]];
        end
    endgenerate
endmodule

// File: rtl/intbyp_sel.sv
module intbyp_sel
    import intbyp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int CONS   = 0
) (
    input  logic [NUNIT-1:0]        p_vld,
    input  logic [NUNIT*TAG_W-1:0]  p_tag,
    input  logic [NUNIT*DATA_W-1:0] p_data,
    input  logic [TAG_W-1:0]        s_tag,
    input  logic [DATA_W-1:0]       rf_val,
    output logic [DATA_W-1:0]       o_val,
    output logic                    o_rdy
);
    logic hit;
    logic blocked;

    always_comb begin
        hit     = 1'b0;
        blocked = 1'b0;
        o_val   = rf_val;
        for (int p = NUNIT - 1; p >= 0; p--) begin
            if (p_vld[p] && (s_tag != '0) && (p_tag[p*TAG_W +: TAG_W] == s_tag)) begin
                if (may_fwd(p, CONS)) begin
                    hit   = 1'b1;
                    o_val = p_data[p*DATA_W +: DATA_W];
                end else begin
                    blocked = 1'b1;
                end
            end
        end
        o_rdy = hit || !blocked;
    end
endmodule

// File: rtl/intbyp_flag_fwd.sv
module intbyp_flag_fwd
    import intbyp_pkg::*;
#(
    parameter int FLAG_W = 4
) (
    input  logic [NALU-1:0]        f_wr,
    input  logic [NALU*FLAG_W-1:0] f_res,
    input  logic [FLAG_W-1:0]      f_held,
    output logic [FLAG_W-1:0]      f_next
);
    always_comb begin
        f_next = f_held;
        for (int a = NALU - 1; a >= 0; a--) begin
            if (f_wr[a])
                f_next = f_res[a*FLAG_W +: FLAG_W];
        end
    end
endmodule

// File: rtl/intbyp_net.sv
module intbyp_net
    import intbyp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int FLAG_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUNIT-1:0]         res_vld,
    input  logic [NUNIT*TAG_W-1:0]   res_tag,
    input  logic [NUNIT*DATA_W-1:0]  res_data,
    input  logic [NALU-1:0]          flg_wr,
    input  logic [NALU*FLAG_W-1:0]   flg_res,
    input  logic [NOPND*TAG_W-1:0]   src_tag,
    output logic [NOPND*DATA_W-1:0]  opnd,
    output logic [NOPND-1:0]         opnd_rdy,
    output logic [FLAG_W-1:0]        alu_flags
);
    typedef struct packed {
        logic [NOPND-1:0][DATA_W-1:0] opnd;
        logic [NOPND-1:0]             rdy;
        logic [FLAG_W-1:0]            flags;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [NOPND*DATA_W-1:0] rf_rd;
    logic [NOPND*DATA_W-1:0] sel_val;
    logic [NOPND-1:0]        sel_rdy;
    logic [FLAG_W-1:0]       flags_nx;

    generate
        for (genvar u = 0; u < NUNIT; u++) begin : g_copy
            intbyp_rf_copy #(
                .DATA_W (DATA_W),
                .TAG_W  (TAG_W)
            ) u_copy (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_vld  (res_vld),
                .wr_tag  (res_tag),
                .wr_data (res_data),
                .rd_tag  (src_tag[u*SRC_PER*TAG_W +: SRC_PER*TAG_W]),
                .rd_data (rf_rd[u*SRC_PER*DATA_W +: SRC_PER*DATA_W])
            );
        end

        for (genvar k = 0; k < NOPND; k++) begin : g_sel
            intbyp_sel #(
                .DATA_W (DATA_W),
                .TAG_W  (TAG_W),
                .CONS   (k / SRC_PER)
            ) u_sel (
                .p_vld  (res_vld),
                .p_tag  (res_tag),
                .p_data (res_data),
                .s_tag  (src_tag[k*TAG_W +: TAG_W]),
                .rf_val (rf_rd[k*DATA_W +: DATA_W]),
                .o_val  (sel_val[k*DATA_W +: DATA_W]),
                .o_rdy  (sel_rdy[k])
            );
        end
    endgenerate

    intbyp_flag_fwd #(
        .FLAG_W (FLAG_W)
    ) u_flag (
        .f_wr   (flg_wr),
        .f_res  (flg_res),
        .f_held (st_q.flags),
        .f_next (flags_nx)
    );

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NOPND; k++) begin
            st_d.opnd[k] = sel_val[k*DATA_W +: DATA_W];
            st_d.rdy[k]  = sel_rdy[k];
        end
        st_d.flags = flags_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.opnd  <= '0;
            st_q.rdy   <= '1;
            st_q.flags <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign opnd      = st_q.opnd;
    assign opnd_rdy  = st_q.rdy;
    assign alu_flags = st_q.flags;
endmodule

// File: rtl/intbyp_net_chk.sv
module intbyp_net_chk
    import intbyp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int FLAG_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUNIT-1:0]         res_vld,
    input  logic [NUNIT*TAG_W-1:0]   res_tag,
    input  logic [NUNIT*DATA_W-1:0]  res_data,
    input  logic [NALU-1:0]          flg_wr,
    input  logic [NALU*FLAG_W-1:0]   flg_res,
    input  logic [NOPND*TAG_W-1:0]   src_tag,
    input  logic [NOPND*DATA_W-1:0]  opnd,
    input  logic [NOPND-1:0]         opnd_rdy,
    input  logic [FLAG_W-1:0]        alu_flags
);
    logic             past_ok;
    logic [NOPND-1:0] any_match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        for (int k = 0; k < NOPND; k++) begin
            any_match[k] = 1'b0;
            for (int u = 0; u < NUNIT; u++) begin
                if (res_vld[u] && (res_tag[u*TAG_W +: TAG_W] != '0) &&
                    (res_tag[u*TAG_W +: TAG_W] == src_tag[k*TAG_W +: TAG_W]))
                    any_match[k] = 1'b1;
            end
        end
    end

    generate
        for (genvar k = 0; k < NOPND; k++) begin : g_k
            // R4
            not_ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && !opnd_rdy[k]) |-> $past(any_match[k]));

            // R2
            alu0_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(res_vld[0] && (res_tag[TAG_W-1:0] != '0) &&
                    (res_tag[TAG_W-1:0] == src_tag[k*TAG_W +: TAG_W])))
                |-> (opnd_rdy[k] && (opnd[k*DATA_W +: DATA_W] == $past(res_data[DATA_W-1:0]))));

            // R7
            zero_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(src_tag[k*TAG_W +: TAG_W] == '0))
                |-> (opnd_rdy[k] && (opnd[k*DATA_W +: DATA_W] == '0)));

            // R9
            copy_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past((src_tag[k*TAG_W +: TAG_W] == src_tag[TAG_W-1:0]) &&
                    !any_match[k] && !any_match[0]))
                |-> (opnd[k*DATA_W +: DATA_W] == opnd[DATA_W-1:0]));
        end
    endgenerate

    // R8
    flags_alu0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(flg_wr[0])) |-> (alu_flags == $past(flg_res[FLAG_W-1:0])));

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(flg_wr == '0)) |-> $stable(alu_flags));
endmodule

bind intbyp_net intbyp_net_chk #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .FLAG_W (FLAG_W)
) u_chk (.*);

// File: tb/intbyp_net_bench.sv
module intbyp_net_bench;
    localparam int DW = 32;
    localparam int TW = 4;
    localparam int FW = 4;
    localparam int NU = 4;
    localparam int NK = 8;
    localparam int NR = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NU-1:0]    res_vld = '0;
    logic [NU*TW-1:0] res_tag = '0;
    logic [NU*DW-1:0] res_data = '0;
    logic [1:0]       flg_wr = '0;
    logic [2*FW-1:0]  flg_res = '0;
    logic [NK*TW-1:0] src_tag = '0;
    logic [NK*DW-1:0] opnd;
    logic [NK-1:0]    opnd_rdy;
    logic [FW-1:0]    alu_flags;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] ref_rf [NR];
    logic [FW-1:0] ref_fl;

    always #2.5 clk = ~clk;

    intbyp_net #(.DATA_W(DW), .TAG_W(TW), .FLAG_W(FW)) u_intbyp_net (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_tag(res_tag),
        .res_data(res_data), .flg_wr(flg_wr), .flg_res(flg_res),
        .src_tag(src_tag), .opnd(opnd), .opnd_rdy(opnd_rdy), .alu_flags(alu_flags)
    );

    function automatic logic allowed(input int p, input int c);
        if (p == 0 || p == 1) return 1'b1;
        if (p == 2) return c == 0;
        return c == 1;
    endfunction

    function automatic logic [DW-1:0] mkval(input int t, input int u, input int s);
        return (32'h01010101 * t) ^ (u << 28) ^ (s * 32'h00009e37);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        res_vld = '0; res_tag = '0; res_data = '0;
        flg_wr = '0; flg_res = '0; src_tag = '0;
    endtask

    task automatic put(input int u, input int t, input logic [DW-1:0] v);
        res_vld[u] = 1'b1;
        res_tag[u*TW +: TW] = TW'(t);
        res_data[u*DW +: DW] = v;
    endtask

    task automatic read_all(input int t);
        for (int k = 0; k < NK; k++) src_tag[k*TW +: TW] = TW'(t);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic read_back(input string req, input int t);
        idle(); read_all(t); step();
        for (int k = 0; k < NK; k++) begin
            check(req, DW'(opnd_rdy[k]), 1);
            check(req, opnd[k*DW +: DW], ref_rf[t]);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int r = 0; r < NR; r++) ref_rf[r] = '0;
        ref_fl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R10 reset state
        check("R10", opnd[DW-1:0] | opnd[NK*DW-1 -: DW], 0);
        check("R10", DW'(opnd_rdy), 32'hff);
        check("R10", DW'(alu_flags), 0);
        read_back("R10", 9);

        // R5 R9: fill every register, then read a different entry on each operand
        for (int t = 1; t < NR; t++) begin
            idle(); put(t % NU, t, mkval(t, t % NU, 1)); ref_rf[t] = mkval(t, t % NU, 1); step();
        end
        for (int t = 0; t < NR; t++) begin
            idle();
            for (int k = 0; k < NK; k++) src_tag[k*TW +: TW] = TW'((t + k) % NR);
            step();
            for (int k = 0; k < NK; k++) begin
                check("R5", DW'(opnd_rdy[k]), 1);
                check("R9", opnd[k*DW +: DW], ref_rf[(t + k) % NR]);
            end
        end

        // R2 R3 R4 R1: every producer on every tag
        for (int p = 0; p < NU; p++) begin
            for (int t = 1; t < NR; t++) begin
                logic [DW-1:0] v;
                v = mkval(t, p, 7 + p);
                idle(); put(p, t, v); read_all(t); step();
                for (int k = 0; k < NK; k++) begin
                    if (allowed(p, k / 2)) begin
                        check(p < 2 ? "R2" : "R3", DW'(opnd_rdy[k]), 1);
                        check(p < 2 ? "R2" : "R3", opnd[k*DW +: DW], v);
                    end else begin
                        check("R4", DW'(opnd_rdy[k]), 0);
                    end
                end
                ref_rf[t] = v;
                read_back("R1", t);
            end
        end

        // R6: ALU1 and AGU1 on one tag
        idle(); put(1, 5, 32'haaaa0001); put(3, 5, 32'hbbbb0003); read_all(5); step();
        for (int k = 0; k < NK; k++) begin
            check("R6", DW'(opnd_rdy[k]), 1);
            check("R6", opnd[k*DW +: DW], 32'haaaa0001);
        end
        ref_rf[5] = 32'haaaa0001;
        read_back("R6", 5);

        // R6: both AGUs on one tag
        idle(); put(2, 6, 32'hcccc0002); put(3, 6, 32'hdddd0003); read_all(6); step();
        for (int k = 0; k < NK; k++) begin
            if (k / 2 == 0) begin
                check("R6", DW'(opnd_rdy[k]), 1); check("R6", opnd[k*DW +: DW], 32'hcccc0002);
            end else if (k / 2 == 1) begin
                check("R6", DW'(opnd_rdy[k]), 1); check("R6", opnd[k*DW +: DW], 32'hdddd0003);
            end else begin
                check("R6", DW'(opnd_rdy[k]), 0);
            end
        end
        ref_rf[6] = 32'hcccc0002;
        read_back("R6", 6);

        // R6: both ALUs on one tag
        idle(); put(0, 7, 32'h0e0e0000); put(1, 7, 32'h1e1e0001); read_all(7); step();
        for (int k = 0; k < NK; k++) check("R6", opnd[k*DW +: DW], 32'h0e0e0000);
        ref_rf[7] = 32'h0e0e0000;
        read_back("R6", 7);

        // R7: tag 0 never written, never forwarded
        for (int u = 0; u < NU; u++) begin
            idle(); put(u, 0, 32'hdeadbeef); read_all(0); step();
            for (int k = 0; k < NK; k++) begin
                check("R7", DW'(opnd_rdy[k]), 1);
                check("R7", opnd[k*DW +: DW], 0);
            end
        end
        read_back("R7", 0);

        // R8: flags forwarding, priority and hold
        for (int m = 1; m < 4; m++) begin
            for (int f = 0; f < 16; f++) begin
                idle(); flg_wr = 2'(m); flg_res = {FW'(~f), FW'(f)}; step();
                ref_fl = (m & 1) ? FW'(f) : FW'(~f);
                check("R8", DW'(alu_flags), DW'(ref_fl));
                idle(); flg_res = {FW'(f + 3), FW'(f + 5)}; step();
                check("R8", DW'(alu_flags), DW'(ref_fl));
            end
        end

        summary();
    end
endmodule